// File: doc/BRIEF.md
# Two-Channel Request-Driven DMA Engine

This block moves data from a source address to a destination address without processor help. It has two channels. Each channel holds its own source pointer, destination pointer, unit count, unit width (byte, half-word or word), a step direction for each pointer, a burst option and a request mode. Software loads a channel with a load strobe, starts it with a start strobe and can halt it with a stop strobe. A channel can also be triggered by its own active-low external request line. Each channel raises a done flag when its count runs out. It also has an interrupt output, which is gated by a live per-channel mask.

One shared master port carries all traffic, using a plain valid/ready handshake. Every unit is a read beat from the source followed by a write beat of the read data to the destination. The read data sits in the low lanes and the low `size` bytes are meaningful. Channel 0 has fixed priority over channel 1. The choice between channels is made only when the mover is idle, so a four-unit burst is never split.

Top module: `dma2ch`

## Requirements
- R1: After reset, `m_valid_o`, every `done_o` bit and every `irq_o` bit are 0.
- R2: Each unit is a read (`m_write_o`=0) at the source pointer, then a write (`m_write_o`=1) of the read data to the destination pointer. `m_size_o` carries the width code (0 = byte, 1 = half-word, 2 = word). A beat holds its address and direction until `m_ready_i` is seen high.
- R3: After each unit, each pointer moves by 1, 2 or 4 bytes according to the width. Direction bit 0 increments the pointer and direction bit 1 decrements it.
- R4: In mode 0 (single), each request moves one unit, or up to four consecutive units when burst is set. A request is a start strobe or a high-to-low change of the request line.
- R5: In mode 1 (block), one request moves the whole loaded count.
- R6: In mode 2 (demand), an enabled channel moves units while its request line is low. When the line goes high, the channel pauses after the unit or burst in progress.
- R7: When the count reaches zero, done is set and the channel disables itself. Start strobes then move nothing until the next load.
- R8: `irq_o` of a channel is high exactly when its done flag and its `irq_en_i` bit are both high.
- R9: A stop strobe disables a channel once the unit in progress is complete. The remaining count and the pointers are kept, and a later start resumes from them.
- R10: When both channels are ready at an idle point, channel 0 is served first. A burst that has begun is not interrupted by the other channel.
- R11: A load clears the channel's done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | NCH | Per-channel strobe that loads the configuration |
| start_i | input | NCH | Per-channel software start / request strobe |
| stop_i | input | NCH | Per-channel stop strobe |
| src_i | input | NCH x AW | Source start address |
| dst_i | input | NCH x AW | Destination start address |
| cnt_i | input | NCH x CNTW | Unit count |
| width_i | input | NCH x 2 | Width code: 0 byte, 1 half, 2 word |
| src_dec_i | input | NCH | 1 = source pointer decrements |
| dst_dec_i | input | NCH | 1 = destination pointer decrements |
| burst_i | input | NCH | Four-unit burst per grant |
| mode_i | input | NCH x 2 | 0 single, 1 block, 2 demand |
| irq_en_i | input | NCH | Interrupt mask, 1 = enabled |
| xreq_ni | input | NCH | External request, active low, synchronous |
| done_o | output | NCH | Count exhausted |
| irq_o | output | NCH | Masked completion interrupt |
| m_valid_o | output | 1 | Master beat valid |
| m_write_o | output | 1 | 1 = write beat |
| m_addr_o | output | AW | Beat address |
| m_size_o | output | 2 | Beat width code |
| m_wdata_o | output | DW | Write data |
| m_rdata_i | input | DW | Read data |
| m_ready_i | input | 1 | Slave accepts beat |

## Verification
The hardest case to reach is a second channel becoming ready while the other channel is partway through a burst. The bench starts a burst on channel 1, waits for the write log to show the first unit of that burst, and only then strobes channel 0. The write log must then show three more channel-1 writes before the first channel-0 write. Stopping a channel in the middle of a block and pausing demand mode by releasing the request line are reached the same way: the bench watches the write count and acts at the moment it changes. Throughout, the slave's ready signal is random, so beats are stretched by different amounts.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  typedef enum logic [1:0] {MODE_SINGLE = 2'd0, MODE_BLOCK = 2'd1, MODE_DEMAND = 2'd2} mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} mv_state_e;

  function automatic logic [2:0] unit_bytes(input logic [1:0] w);
    return (w == 2'd0) ? 3'd1 : (w == 2'd1) ? 3'd2 : 3'd4;
  endfunction
endpackage

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CNTW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [AW-1:0]   src_i,
  input  logic [AW-1:0]   dst_i,
  input  logic [CNTW-1:0] cnt_i,
  input  logic [1:0]      width_i,
  input  logic            src_dec_i,
  input  logic            dst_dec_i,
  input  logic            burst_i,
  input  logic [1:0]      mode_i,
  input  logic            xreq_ni,
  input  logic            take_i,
  input  logic            adv_i,
  output logic            ready_o,
  output logic            en_o,
  output logic [AW-1:0]   src_o,
  output logic [AW-1:0]   dst_o,
  output logic [CNTW-1:0] cnt_o,
  output logic [1:0]      width_o,
  output logic            burst_o,
  output logic            done_o
);
  logic [AW-1:0]   src_q, dst_q;
  logic [CNTW-1:0] cnt_q;
  logic [1:0]      width_q, mode_q;
  logic            sdec_q, ddec_q, burst_q, en_q, pend_q, done_q, xreq_q;
  logic            xfall, req, last;
  logic [AW-1:0]   step;

  assign xfall = xreq_q & ~xreq_ni;
  assign req   = start_i | (xfall & (mode_q != MODE_DEMAND));
  assign last  = adv_i && (cnt_q == CNTW'(1));
  assign step  = AW'(unit_bytes(width_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; width_q <= '0; mode_q <= '0;
      sdec_q <= 1'b0; ddec_q <= 1'b0; burst_q <= 1'b0;
      en_q <= 1'b0; pend_q <= 1'b0; done_q <= 1'b0; xreq_q <= 1'b1;
    end else begin
      xreq_q <= xreq_ni;
      if (load_i) begin
        src_q <= src_i; dst_q <= dst_i; cnt_q <= cnt_i; width_q <= width_i;
        mode_q <= mode_i; sdec_q <= src_dec_i; ddec_q <= dst_dec_i; burst_q <= burst_i;
        en_q <= 1'b0; pend_q <= 1'b0; done_q <= 1'b0;
      end else begin
        if (adv_i) begin
          src_q <= sdec_q ? src_q - step : src_q + step;
          dst_q <= ddec_q ? dst_q - step : dst_q + step;
          cnt_q <= cnt_q - CNTW'(1);
        end
        if (last) begin
          done_q <= 1'b1; en_q <= 1'b0; pend_q <= 1'b0;
        end else begin
          if (start_i && !done_q) en_q <= 1'b1;
          else if (stop_i)        en_q <= 1'b0;
          if (req && !done_q)                        pend_q <= 1'b1;
          else if (take_i && mode_q == MODE_SINGLE)  pend_q <= 1'b0;
        end
      end
    end
  end

  assign ready_o = en_q && (cnt_q != '0) && ((mode_q == MODE_DEMAND) ? !xreq_ni : pend_q);
  assign en_o    = en_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign cnt_o   = cnt_q;
  assign width_o = width_q;
  assign burst_o = burst_q;
  assign done_o  = done_q;

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CNTW'(1))); // R5
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!en_q && cnt_q == '0)); // R7
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !load_i |=> done_q && !ready_o); // R7
  AST_LOAD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !done_q); // R11
endmodule

// File: rtl/dma2ch_arb.sv
module dma2ch_arb #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins: scan downward, last hit stands
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o = N'(1) << i;
        idx_o = IW'(i);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dma2ch_mover.sv
module dma2ch_mover
  import dma2ch_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CNTW = 16,
  parameter int IW   = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      any_i,
  input  logic [IW-1:0]             idx_i,
  input  logic [NCH-1:0]            gnt_i,
  input  logic [NCH-1:0]            en_i,
  input  logic [NCH-1:0]            burst_i,
  input  logic [NCH-1:0][CNTW-1:0]  cnt_i,
  input  logic [NCH-1:0][AW-1:0]    src_i,
  input  logic [NCH-1:0][AW-1:0]    dst_i,
  input  logic [NCH-1:0][1:0]       width_i,
  output logic [NCH-1:0]            take_o,
  output logic [NCH-1:0]            adv_o,
  output logic                      m_valid_o,
  output logic                      m_write_o,
  output logic [AW-1:0]             m_addr_o,
  output logic [1:0]                m_size_o,
  output logic [DW-1:0]             m_wdata_o,
  input  logic [DW-1:0]             m_rdata_i,
  input  logic                      m_ready_i
);
  mv_state_e     state_q;
  logic [IW-1:0] cur_q;
  logic [1:0]    beat_q;
  logic [DW-1:0] data_q;
  logic          more;

  // burst continues only inside the four-unit window, with count and enable left
  assign more = burst_i[cur_q] && (beat_q != 2'd3) && (cnt_i[cur_q] > CNTW'(1)) && en_i[cur_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; cur_q <= '0; beat_q <= '0; data_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (any_i) begin
          cur_q <= idx_i; beat_q <= '0; state_q <= ST_RD;
        end
        ST_RD: if (m_ready_i) begin
          data_q <= m_rdata_i; state_q <= ST_WR;
        end
        ST_WR: if (m_ready_i) begin
          beat_q  <= beat_q + 2'd1;
          state_q <= more ? ST_RD : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign take_o    = (state_q == ST_IDLE && any_i) ? gnt_i : '0;
  assign adv_o     = (state_q == ST_WR && m_ready_i) ? (NCH'(1) << cur_q) : '0;
  assign m_valid_o = (state_q != ST_IDLE);
  assign m_write_o = (state_q == ST_WR);
  assign m_addr_o  = (state_q == ST_WR) ? dst_i[cur_q] : src_i[cur_q];
  assign m_size_o  = width_i[cur_q];
  assign m_wdata_o = data_q;

  AST_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_valid_o && !m_ready_i |=> m_valid_o && $stable(m_addr_o) && $stable(m_write_o)); // R2
  AST_BURST_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != ST_IDLE |=> state_q == ST_IDLE || $stable(cur_q)); // R10
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_RD && m_ready_i |=> m_write_o); // R2
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int CNTW = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCH-1:0]            load_i,
  input  logic [NCH-1:0]            start_i,
  input  logic [NCH-1:0]            stop_i,
  input  logic [NCH-1:0][AW-1:0]    src_i,
  input  logic [NCH-1:0][AW-1:0]    dst_i,
  input  logic [NCH-1:0][CNTW-1:0]  cnt_i,
  input  logic [NCH-1:0][1:0]       width_i,
  input  logic [NCH-1:0]            src_dec_i,
  input  logic [NCH-1:0]            dst_dec_i,
  input  logic [NCH-1:0]            burst_i,
  input  logic [NCH-1:0][1:0]       mode_i,
  input  logic [NCH-1:0]            irq_en_i,
  input  logic [NCH-1:0]            xreq_ni,
  output logic [NCH-1:0]            done_o,
  output logic [NCH-1:0]            irq_o,
  output logic                      m_valid_o,
  output logic                      m_write_o,
  output logic [AW-1:0]             m_addr_o,
  output logic [1:0]                m_size_o,
  output logic [DW-1:0]             m_wdata_o,
  input  logic [DW-1:0]             m_rdata_i,
  input  logic                      m_ready_i
);
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0]           ready, en, burst, take, adv, gnt;
  logic [NCH-1:0][CNTW-1:0] cnt;
  logic [NCH-1:0][AW-1:0]   src, dst;
  logic [NCH-1:0][1:0]      width;
  logic [IW-1:0]            idx;
  logic                     any;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma2ch_chan #(.AW(AW), .CNTW(CNTW)) u_chan (
      .clk_i, .rst_ni,
      .load_i(load_i[c]), .start_i(start_i[c]), .stop_i(stop_i[c]),
      .src_i(src_i[c]), .dst_i(dst_i[c]), .cnt_i(cnt_i[c]), .width_i(width_i[c]),
      .src_dec_i(src_dec_i[c]), .dst_dec_i(dst_dec_i[c]), .burst_i(burst_i[c]),
      .mode_i(mode_i[c]), .xreq_ni(xreq_ni[c]),
      .take_i(take[c]), .adv_i(adv[c]),
      .ready_o(ready[c]), .en_o(en[c]), .src_o(src[c]), .dst_o(dst[c]),
      .cnt_o(cnt[c]), .width_o(width[c]), .burst_o(burst[c]), .done_o(done_o[c])
    );
  end

  dma2ch_arb #(.N(NCH), .IW(IW)) u_arb (
    .req_i(ready), .gnt_o(gnt), .idx_o(idx), .any_o(any)
  );

  dma2ch_mover #(.NCH(NCH), .AW(AW), .DW(DW), .CNTW(CNTW), .IW(IW)) u_mover (
    .clk_i, .rst_ni, .any_i(any), .idx_i(idx), .gnt_i(gnt),
    .en_i(en), .burst_i(burst), .cnt_i(cnt), .src_i(src), .dst_i(dst), .width_i(width),
    .take_o(take), .adv_o(adv),
    .m_valid_o, .m_write_o, .m_addr_o, .m_size_o, .m_wdata_o, .m_rdata_i, .m_ready_i
  );

  assign irq_o = done_o & irq_en_i;

  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> done_o[0] && irq_en_i[0]); // R8
endmodule

// File: tb/dma2ch_test.sv
module dma2ch_test;
  localparam int NCH = 2, AW = 32, DW = 32, CNTW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NCH-1:0] load = '0, start = '0, stop = '0, sdec = '0, ddec = '0, burst = '0;
  logic [NCH-1:0] irq_en = '0, xreq_n = '1, done, irq;
  logic [NCH-1:0][AW-1:0] src = '0, dst = '0;
  logic [NCH-1:0][CNTW-1:0] cnt = '0;
  logic [NCH-1:0][1:0] width = '0, mode = '0;
  logic m_valid, m_write, m_ready = 1'b0;
  logic [AW-1:0] m_addr;
  logic [1:0] m_size;
  logic [DW-1:0] m_wdata, m_rdata;

  dma2ch uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .start_i(start), .stop_i(stop),
    .src_i(src), .dst_i(dst), .cnt_i(cnt), .width_i(width), .src_dec_i(sdec),
    .dst_dec_i(ddec), .burst_i(burst), .mode_i(mode), .irq_en_i(irq_en),
    .xreq_ni(xreq_n), .done_o(done), .irq_o(irq), .m_valid_o(m_valid),
    .m_write_o(m_write), .m_addr_o(m_addr), .m_size_o(m_size), .m_wdata_o(m_wdata),
    .m_rdata_i(m_rdata), .m_ready_i(m_ready)
  );

  logic [7:0] mem [0:1023];
  logic [7:0] ref_mem [0:1023];
  int wcnt = 0, rd_seen = 0, bad_order = 0;
  logic [AW-1:0] wlog [0:1023];
  int checks = 0, fails = 0;
  bit finished = 0;

  function automatic int nbytes(input logic [1:0] w);
    return (w == 2'd0) ? 1 : (w == 2'd1) ? 2 : 4;
  endfunction

  always_comb begin
    m_rdata = '0;
    for (int k = 0; k < 4; k++)
      if (k < nbytes(m_size)) m_rdata[8*k +: 8] = mem[(m_addr[9:0] + 10'(k))];
  end

  always @(negedge clk) m_ready <= ($urandom % 4) != 0;

  // slave model: memory update, write log, read-before-write tracking
  always @(posedge clk) begin
    if (m_valid && m_ready) begin
      if (m_write) begin
        for (int k = 0; k < nbytes(m_size); k++) mem[m_addr[9:0] + 10'(k)] <= m_wdata[8*k +: 8];
        if (rd_seen == 0) bad_order <= bad_order + 1;
        rd_seen <= 0;
        wlog[wcnt % 1024] <= m_addr;
        wcnt <= wcnt + 1;
      end else rd_seen <= 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) d++;
    return d;
  endfunction

  task automatic ref_copy(input int s, input int d, input int c, input int w,
                          input bit sd, input bit dd);
    int st = nbytes(2'(w));
    for (int u = 0; u < c; u++) begin
      for (int k = 0; k < st; k++) ref_mem[(d + k) % 1024] = ref_mem[(s + k) % 1024];
      s = sd ? s - st : s + st;
      d = dd ? d - st : d + st;
    end
  endtask

  task automatic prog(input int ch, input int s, input int d, input int c, input int w,
                      input bit sd, input bit dd, input bit b, input int m);
    @(negedge clk);
    src[ch] = AW'(s); dst[ch] = AW'(d); cnt[ch] = CNTW'(c); width[ch] = 2'(w);
    sdec[ch] = sd; ddec[ch] = dd; burst[ch] = b; mode[ch] = 2'(m); load[ch] = 1'b1;
    @(negedge clk);
    load[ch] = 1'b0;
  endtask

  task automatic pulse_start(input int ch);
    @(negedge clk); start[ch] = 1'b1; @(negedge clk); start[ch] = 1'b0;
  endtask

  task automatic pulse_stop(input int ch);
    @(negedge clk); stop[ch] = 1'b1; @(negedge clk); stop[ch] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done(input int ch, input string req);
    int t = 0;
    while (!done[ch] && t < 5000) begin @(negedge clk); t++; end
    chk(done[ch] == 1'b1, req, int'(done[ch]), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int base, d1, d2, s, d, c, w, m;
    bit sd, dd, b;
    void'($urandom(32'h1d0a5eed));
    for (int i = 0; i < 1024; i++) begin mem[i] = 8'($urandom); ref_mem[i] = mem[i]; end
    idle(3);
    // R1 reset state
    chk(m_valid == 1'b0 && done == '0 && irq == '0, "R1", int'({m_valid, done, irq}), 0);
    rst_n = 1'b1;
    idle(2);
    chk(m_valid == 1'b0 && done == '0, "R1", int'({m_valid, done}), 0);

    // R5/R2/R3 block, word, increment
    base = wcnt;
    prog(0, 'h000, 'h200, 8, 2, 0, 0, 0, 1);
    ref_copy('h000, 'h200, 8, 2, 0, 0);
    pulse_start(0);
    wait_done(0, "R5");
    idle(2);
    chk(wcnt - base == 8, "R5", wcnt - base, 8);
    chk(mem_diff() == 0, "R3", mem_diff(), 0);
    chk(bad_order == 0, "R2", bad_order, 0);
    // R8 masking
    chk(irq[0] == 1'b0, "R8", int'(irq[0]), 0);
    @(negedge clk); irq_en[0] = 1'b1; @(negedge clk);
    chk(irq[0] == 1'b1, "R8", int'(irq[0]), 1);
    // R7 start after done moves nothing
    base = wcnt;
    pulse_start(0); idle(30);
    chk(wcnt == base && done[0], "R7", wcnt - base, 0);
    // R11 load clears done
    prog(0, 'h040, 'h240, 6, 0, 0, 0, 1, 0);
    chk(done[0] == 1'b0 && irq[0] == 1'b0, "R11", int'(done[0]), 0);

    // R4 single with burst, byte: 4 then 2
    ref_copy('h040, 'h240, 6, 0, 0, 0);
    base = wcnt;
    pulse_start(0); idle(40);
    chk(wcnt - base == 4, "R4", wcnt - base, 4);
    pulse_start(0); idle(40);
    chk(wcnt - base == 6 && done[0], "R4", wcnt - base, 6);
    chk(mem_diff() == 0, "R4", mem_diff(), 0);

    // R4/R3 single no burst, half-word, source decrement, external edge
    prog(1, 'h0FE, 'h300, 3, 1, 1, 0, 0, 0);
    ref_copy('h0FE, 'h300, 3, 1, 1, 0);
    base = wcnt;
    pulse_start(1); idle(30);
    chk(wcnt - base == 1, "R4", wcnt - base, 1);
    @(negedge clk); xreq_n[1] = 1'b0; @(negedge clk); xreq_n[1] = 1'b1;
    idle(30);
    chk(wcnt - base == 2, "R4", wcnt - base, 2);
    pulse_start(1);
    wait_done(1, "R4");
    chk(mem_diff() == 0, "R3", mem_diff(), 0);

    // R6 demand mode
    prog(1, 'h100, 'h320, 40, 2, 0, 0, 0, 2);
    ref_copy('h100, 'h320, 40, 2, 0, 0);
    base = wcnt;
    pulse_start(1); idle(20);
    chk(wcnt == base, "R6", wcnt - base, 0);
    @(negedge clk); xreq_n[1] = 1'b0;
    idle(30);
    @(negedge clk); xreq_n[1] = 1'b1;
    idle(30);
    d1 = wcnt - base;
    chk(d1 > 0 && d1 < 40, "R6", d1, 20);
    idle(50);
    chk(wcnt - base == d1 && !done[1], "R6", wcnt - base, d1);
    @(negedge clk); xreq_n[1] = 1'b0;
    wait_done(1, "R6");
    @(negedge clk); xreq_n[1] = 1'b1;
    chk(mem_diff() == 0, "R6", mem_diff(), 0);

    // R9 stop and resume
    prog(0, 'h080, 'h380, 30, 2, 0, 0, 0, 1);
    ref_copy('h080, 'h380, 30, 2, 0, 0);
    base = wcnt;
    pulse_start(0);
    while (wcnt - base < 5) @(negedge clk);
    pulse_stop(0); idle(30);
    d1 = wcnt - base;
    chk(d1 < 30 && !done[0], "R9", d1, 10);
    idle(40);
    chk(wcnt - base == d1, "R9", wcnt - base, d1);
    pulse_start(0);
    wait_done(0, "R9");
    idle(2);
    chk(wcnt - base == 30 && mem_diff() == 0, "R9", wcnt - base, 30);

    // R10 simultaneous starts: channel 0 first
    prog(0, 'h000, 'h200, 4, 2, 0, 0, 0, 1);
    prog(1, 'h010, 'h300, 4, 2, 0, 0, 0, 1);
    ref_copy('h000, 'h200, 4, 2, 0, 0);
    ref_copy('h010, 'h300, 4, 2, 0, 0);
    base = wcnt;
    @(negedge clk); start = 2'b11; @(negedge clk); start = 2'b00;
    wait_done(0, "R10"); wait_done(1, "R10");
    idle(2);
    chk(wlog[base % 1024] == 32'h200, "R10", int'(wlog[base % 1024]), 'h200);

    // R10 burst not split by channel 0
    prog(1, 'h100, 'h300, 8, 0, 0, 0, 1, 1);
    prog(0, 'h080, 'h240, 4, 2, 0, 0, 0, 1);
    ref_copy('h100, 'h300, 8, 0, 0, 0);
    ref_copy('h080, 'h240, 4, 2, 0, 0);
    base = wcnt;
    pulse_start(1);
    while (wcnt - base < 1) @(negedge clk);
    pulse_start(0);
    wait_done(0, "R10"); wait_done(1, "R10");
    idle(2);
    d2 = 0;
    for (int i = 0; i < 4; i++) if (wlog[(base + i) % 1024] >= 32'h300) d2++;
    chk(d2 == 4, "R10", d2, 4);
    chk(wlog[(base + 4) % 1024] == 32'h240, "R10", int'(wlog[(base + 4) % 1024]), 'h240);
    chk(mem_diff() == 0, "R10", mem_diff(), 0);

    // random transfers
    for (int t = 0; t < 8; t++) begin
      int ch = t % 2;
      c = 1 + ($urandom % 12); w = $urandom % 3;
      sd = 1'($urandom); dd = 1'($urandom); b = 1'($urandom);
      m = ($urandom % 2 == 0) ? 1 : 0;
      s = ($urandom % 64) * 4; d = 'h200 + ($urandom % 96) * 4;
      if (sd) s = s + (c - 1) * nbytes(2'(w));
      if (dd) d = d + (c - 1) * nbytes(2'(w));
      prog(ch, s, d, c, w, sd, dd, b, m);
      ref_copy(s, d, c, w, sd, dd);
      base = wcnt;
      for (int k = 0; k < 100 && !done[ch]; k++) begin pulse_start(ch); idle(40); end
      wait_done(ch, "R5");
      idle(2);
      chk(wcnt - base == c, "R3", wcnt - base, c);
      chk(mem_diff() == 0, "R2", mem_diff(), 0);
    end
    chk(bad_order == 0, "R2", bad_order, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule